// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a binary up counter whose bits all update on one shared clock edge. On each edge a small priority decoder picks one action: clear to zero, preset from a parallel data word, increment, or hold. Both control inputs that force a value (clear and preset) are active low and take effect only at the clock edge.

Counting needs two enables at once. The first, `cnt_en`, gates the local increment only. The second, `chain_en`, gates the increment and also qualifies the terminal-count flag `carry_out`. Wider counters are built by feeding one stage's `carry_out` into the next stage's `chain_en`, with a common `cnt_en` on all stages. The higher stage then steps exactly once each time every lower stage sits at its all-ones value while enabled.

The width is a parameter and defaults to 4 bits (count range 0 to 15).

Top module: `sync_preset_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 after that edge.
- R2: With `rst` low, `clear_n` low at an edge makes the count 0. This holds whatever `preset_n`, `data_in` and both enables are doing.
- R3: With `rst` low and `clear_n` high, `preset_n` low at an edge loads `data_in` into the count. This happens whatever the enables are doing.
- R4: With `rst` low, `clear_n` high, `preset_n` high and both `cnt_en` and `chain_en` high, the count rises by one at each edge. From the all-ones value (15 at the default width) it wraps to 0.
- R5: With `rst` low, `clear_n` high and `preset_n` high, if `cnt_en` or `chain_en` is low, the count keeps its value across the edge.
- R6: `carry_out` is combinational. It is 1 exactly when `chain_en` is 1 and the count is all ones, and it does not depend on `cnt_en`.
- R7: A clear, then a preset to 12, then six counting edges give the count values 12, 13, 14, 15, 0, 1, 2. Dropping `cnt_en` after that leaves the count at 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear_n | input | 1 | Synchronous clear, active low, highest control priority |
| preset_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | WIDTH | Value loaded on a preset |
| cnt_en | input | 1 | Count enable that gates only the increment |
| chain_en | input | 1 | Count enable that also qualifies `carry_out` |
| count_q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count flag for cascading |

## Verification
The bench drives clear and preset low together to check that clear wins; a design with the priority swapped would load the data instead of returning to zero. It presets while both enables are low, because a preset wrongly gated by an enable would leave the old count in place. At the all-ones value it toggles each enable on its own. This catches a carry that follows `cnt_en`, or one that ignores `chain_en`, and also catches a count that moves with only one enable high. It also checks the wrap from 15 to 0, where a carry chain that drops the top bit would stall or jump to a wrong value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clear_n;
        logic preset_n;
        logic cnt_en;
        logic chain_en;
    } cnt_ctl_t;

    // Fixed priority: clear, then preset, then increment, else hold.
    function automatic cnt_op_e decode_op(input cnt_ctl_t c);
        if (!c.clear_n)
            return OP_CLEAR;
        else if (!c.preset_n)
            return OP_LOAD;
        else if (c.cnt_en && c.chain_en)
            return OP_INC;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
    import cnt_pkg::*;
(
    input  cnt_ctl_t ctl,
    output cnt_op_e  op
);

    always_comb begin
        op = decode_op(ctl);
    end

endmodule

// File: rtl/cnt_state.sv
module cnt_state
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] q
);

    // Per-bit toggle terms: a bit flips when every lower bit is one.
    logic [WIDTH-1:0] tgl;
    logic [WIDTH-1:0] inc_val;

    assign tgl[0] = 1'b1;

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_tgl
            assign tgl[i] = tgl[i-1] & q[i-1];
        end
    endgenerate

    assign inc_val = q ^ tgl;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= data_in;
                OP_INC:   q <= inc_val;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             carry_out
);

    // Terminal count: all bits one. Only chain_en gates the flag.
    assign carry_out = chain_en & (&q);

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_n,
    input  logic             preset_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

    cnt_ctl_t ctl;
    cnt_op_e  op;

    assign ctl = '{clear_n: clear_n, preset_n: preset_n,
                   cnt_en: cnt_en, chain_en: chain_en};

    cnt_ctrl u_ctrl (
        .ctl (ctl),
        .op  (op)
    );

    cnt_state #(.WIDTH(WIDTH)) u_state (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .data_in (data_in),
        .q       (count_q)
    );

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .q         (count_q),
        .chain_en  (chain_en),
        .carry_out (carry_out)
    );

    // R1: reset returns the count to zero
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> count_q == '0);

    // R2: clear wins over every other control
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> count_q == '0);

    // R3: preset loads regardless of the enables
    a_r3_preset_load: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !preset_n) |=> count_q == $past(data_in));

    // R4: both enables step the count by one, wrapping
    a_r4_increment: assert property (@(posedge clk) disable iff (rst)
        (clear_n && preset_n && cnt_en && chain_en)
        |=> count_q == $past(count_q) + ONE);

    // R5: either enable low holds the count
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (clear_n && preset_n && !(cnt_en && chain_en)) |=> $stable(count_q));

    // R6: carry tracks chain_en and the terminal value, not cnt_en
    a_r6_carry_flag: assert property (@(posedge clk) disable iff (rst)
        carry_out == (chain_en && count_q == FULL));

endmodule

// File: tb/tb_sync_preset_counter.sv
module tb_sync_preset_counter;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst, clear_n, preset_n, cnt_en, chain_en;
    logic [W-1:0] data_in;
    logic [W-1:0] count_q;
    logic         carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sync_preset_counter #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .clear_n(clear_n), .preset_n(preset_n),
        .data_in(data_in), .cnt_en(cnt_en), .chain_en(chain_en),
        .count_q(count_q), .carry_out(carry_out)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // One clock: drive at negedge, check carry before the edge,
    // update the behavioural model at the edge, check the count after it.
    task automatic step(input bit r, input bit cl_n, input bit pr_n,
                        input int d, input bit e1, input bit e2, input string req);
        @(negedge clk);
        rst = r; clear_n = cl_n; preset_n = pr_n;
        data_in = W'(d); cnt_en = e1; chain_en = e2;
        #2;
        chk("R6", "carry_out", int'(carry_out),
            (e2 && model == (1 << W) - 1) ? 1 : 0);
        @(posedge clk);
        if (r)          model = 0;
        else if (!cl_n) model = 0;
        else if (!pr_n) model = d % (1 << W);
        else if (e1 && e2) model = (model + 1) % (1 << W);
        #2;
        chk(req, "count_q", int'(count_q), model);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; clear_n = 1; preset_n = 1; data_in = '0; cnt_en = 0; chain_en = 0;
        step(1, 1, 1, 9, 1, 1, "R1");
        step(1, 1, 1, 9, 1, 1, "R1");

        // R7 sequence: clear, preset 12, count 6 times, inhibit
        step(0, 0, 1, 0, 0, 0, "R2");
        step(0, 1, 0, 12, 0, 0, "R3");
        chk("R7", "preset value", int'(count_q), 12);
        for (int k = 0; k < 6; k++) begin
            step(0, 1, 1, 0, 1, 1, "R4");
            chk("R7", "sequence", int'(count_q), (13 + k) % 16);
        end
        step(0, 1, 1, 0, 0, 1, "R5");
        step(0, 1, 1, 0, 0, 1, "R5");
        chk("R7", "inhibited hold", int'(count_q), 2);

        // R2: clear beats a simultaneous preset and enables
        step(0, 1, 0, 7, 0, 0, "R3");
        step(0, 0, 0, 9, 1, 1, "R2");

        // R3: preset with enables in every combination
        step(0, 1, 0, 15, 1, 0, "R3");
        // R6: carry with cnt_en low but chain_en high
        step(0, 1, 1, 0, 0, 1, "R5");
        // R6: chain_en low at terminal value -> carry 0, hold
        step(0, 1, 1, 0, 1, 0, "R5");
        // R4: wrap 15 -> 0
        step(0, 1, 1, 0, 1, 1, "R4");
        step(0, 1, 0, 14, 1, 1, "R3");
        step(0, 1, 1, 0, 1, 1, "R4");
        step(0, 1, 1, 0, 0, 0, "R5");

        // R1: reset mid-run overrides a preset
        step(1, 1, 0, 5, 1, 1, "R1");

        // Mixed patterns from an LFSR
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 300; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] & lf[1] & lf[2] & lf[3], lf[4] | lf[5] | lf[6],
                     lf[7] | lf[8], int'(lf[12:9]), lf[13] | lf[2], lf[14] | lf[6],
                     "R4");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule